// File: doc/BRIEF.md
# Shifted Coarse Timestamp Generator

This block runs one wide free-running timestamp counter on a 19.2 MHz reference clock and derives three lower-resolution timestamps from it. Each derived stamp is the fast count shifted right by an amount that software programs, and then cut down to 32 bits. Consumers that need coarse time therefore all read slices of the same counter. There is no separate prescaled counter for each consumer.

The three derived stamps serve as a logging stamp, a packet-tag stamp and an aging stamp for address-translation entries. A single 32-bit configuration word holds the three shift amounts. It also holds a select bit that switches the logging stamp between the shifted fast count and a legacy millisecond count. The legacy count is built from the same reference clock by dividing it by 19200. The configuration word is loaded through a write-enable and data pair.

A shift of 14 gives a coarse tick of roughly 853 µs. A shift of 24 gives a coarse tick of roughly 874 ms.

Top module: `coarse_stamp_gen`

## Requirements
- R1: After reset, `base_stamp` is zero. It then rises by exactly one on every clock edge and wraps modulo 2^56.
- R2: `tag_stamp` equals the low 32 bits of `base_stamp` shifted right by config field bits [12:8].
- R3: `age_stamp` equals the low 32 bits of `base_stamp` shifted right by config field bits [20:16].
- R4: When config bit 7 is 1, `log_stamp` equals the low 32 bits of `base_stamp` shifted right by config field bits [4:0].
- R5: When config bit 7 is 0, `log_stamp` is a legacy millisecond count. This count starts at zero at reset and rises by one every 19200 clocks, so it equals floor(`base_stamp` / 19200).
- R6: After reset the config word is all zeros. As a result, `tag_stamp` and `age_stamp` equal the low 32 bits of `base_stamp`, and `log_stamp` shows the millisecond count.
- R7: A write with `cfg_we` high takes effect on the cycle after the clock edge that captures it. The write never disturbs `base_stamp` or the millisecond count.
- R8: Config bits [6:5], [15:13] and [31:21] are ignored: they are stored as zero and have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 19.2 MHz reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Config write strobe |
| cfg_wdata | input | 32 | Config write data |
| base_stamp | output | 56 | Free-running fast timestamp |
| log_stamp | output | 32 | Logging stamp: shifted count or millisecond count |
| tag_stamp | output | 32 | Packet-tag coarse stamp |
| age_stamp | output | 32 | Translation-aging coarse stamp |

## Verification
The hardest output to reach from the ports is the millisecond count. It only moves once every 19200 clocks, so a short run never sees it leave zero. The stimulus therefore runs with the legacy select active across several millisecond boundaries and checks every cycle around each step.

Large shift amounts present a similar problem, because they leave the stamps frozen for a very long time. Random configuration words are therefore mixed with directed shifts of 0, 1, 14, 24 and 31. Garbage is also placed in the unused bits. Every stamp is compared against a bit-by-bit model of the shifted value.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
  localparam int BASE_W  = 56;
  localparam int STAMP_W = 32;
  localparam int SHIFT_W = 5;
  localparam int NUM_TAPS = 3;

  // Configuration word; field positions are software visible.
  typedef struct packed {
    logic [10:0]        rsvd_hi;
    logic [SHIFT_W-1:0] age_shift;
    logic [2:0]         rsvd_mid;
    logic [SHIFT_W-1:0] tag_shift;
    logic               log_sel;
    logic [1:0]         rsvd_lo;
    logic [SHIFT_W-1:0] log_shift;
  } stamp_cfg_t;

  // Clear the reserved fields of a written word.
  function automatic stamp_cfg_t cfg_clean(input logic [31:0] w);
    stamp_cfg_t c;
    c = stamp_cfg_t'(w);
    c.rsvd_hi  = '0;
    c.rsvd_mid = '0;
    c.rsvd_lo  = '0;
    return c;
  endfunction

  // Coarse stamp: right shift of the base count, truncated.
  function automatic logic [STAMP_W-1:0] coarse_of(input logic [BASE_W-1:0] b,
                                                   input logic [SHIFT_W-1:0] sh);
    logic [BASE_W-1:0] t;
    t = b >> sh;
    return t[STAMP_W-1:0];
  endfunction
endpackage

// File: rtl/stamp_base_counter.sv
module stamp_base_counter #(
  parameter int W = 56
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count + 1'b1;
  end
endmodule

// File: rtl/stamp_ms_divider.sv
module stamp_ms_divider #(
  parameter int DIV = 19200,
  parameter int W   = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic         ms_tick,
  output logic [W-1:0] ms_count
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre;

  assign ms_tick = (pre == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre      <= '0;
      ms_count <= '0;
    end else if (ms_tick) begin
      pre      <= '0;
      ms_count <= ms_count + 1'b1;
    end else begin
      pre      <= pre + 1'b1;
    end
  end
endmodule

// File: rtl/stamp_cfg_reg.sv
module stamp_cfg_reg
  import stamp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [31:0] wdata,
  output stamp_cfg_t cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg <= '0;
    else if (we) cfg <= cfg_clean(wdata);
  end
endmodule

// File: rtl/stamp_shift_tap.sv
module stamp_shift_tap
  import stamp_pkg::*;
(
  input  logic [BASE_W-1:0]  base,
  input  logic [SHIFT_W-1:0] shift,
  output logic [STAMP_W-1:0] stamp
);
  assign stamp = coarse_of(base, shift);
endmodule

// File: rtl/coarse_stamp_gen.sv
module coarse_stamp_gen
  import stamp_pkg::*;
#(
  parameter int MS_DIV = 19200
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [31:0]        cfg_wdata,
  output logic [BASE_W-1:0]  base_stamp,
  output logic [STAMP_W-1:0] log_stamp,
  output logic [STAMP_W-1:0] tag_stamp,
  output logic [STAMP_W-1:0] age_stamp
);
  // Named internal events for the checker.
  logic [BASE_W-1:0]  base_q;
  logic [STAMP_W-1:0] ms_count;
  logic               ms_tick;
  stamp_cfg_t         cfg_q;
  logic [SHIFT_W-1:0] tap_shift [NUM_TAPS];
  logic [STAMP_W-1:0] tap_stamp [NUM_TAPS];

  stamp_base_counter #(.W(BASE_W)) u_base (
    .clk(clk), .rst_n(rst_n), .count(base_q)
  );

  stamp_ms_divider #(.DIV(MS_DIV), .W(STAMP_W)) u_ms (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .ms_count(ms_count)
  );

  stamp_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg_q)
  );

  // Tap 0: logging, tap 1: tag, tap 2: translation aging.
  assign tap_shift[0] = cfg_q.log_shift;
  assign tap_shift[1] = cfg_q.tag_shift;
  assign tap_shift[2] = cfg_q.age_shift;

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    stamp_shift_tap u_tap (
      .base(base_q), .shift(tap_shift[g]), .stamp(tap_stamp[g])
    );
  end

  assign base_stamp = base_q;
  assign log_stamp  = cfg_q.log_sel ? tap_stamp[0] : ms_count;
  assign tag_stamp  = tap_stamp[1];
  assign age_stamp  = tap_stamp[2];
endmodule

// File: rtl/stamp_gen_checker.sv
module stamp_gen_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [31:0] cfg_wdata,
  input logic [55:0] base_q,
  input logic [31:0] cfg_q,
  input logic [31:0] ms_count,
  input logic        ms_tick,
  input logic [31:0] log_stamp,
  input logic [31:0] tag_stamp,
  input logic [31:0] age_stamp
);
  AST_BASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> base_q == $past(base_q) + 56'd1); // R1

  AST_TAG_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    tag_stamp[0] == base_q[cfg_q[12:8]]); // R2

  AST_AGE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    age_stamp[0] == base_q[cfg_q[20:16]]); // R3

  AST_LOG_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[7] |-> log_stamp[0] == base_q[cfg_q[4:0]]); // R4

  AST_LEGACY_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[7] |-> log_stamp == ms_count); // R5

  AST_MS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ms_tick |=> ms_count == $past(ms_count) + 32'd1); // R5

  AST_MS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_tick |=> $stable(ms_count)); // R5

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_q == ($past(cfg_wdata) & 32'h001F_1F9F)); // R7

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_q)); // R7

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q & 32'hFFE0_E060) == 32'd0); // R8
endmodule

bind coarse_stamp_gen stamp_gen_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .base_q(base_q), .cfg_q(cfg_q), .ms_count(ms_count), .ms_tick(ms_tick),
  .log_stamp(log_stamp), .tag_stamp(tag_stamp), .age_stamp(age_stamp)
);

// File: tb/tb_coarse_stamp_gen.sv
module tb_coarse_stamp_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [55:0] base_stamp;
  logic [31:0] log_stamp, tag_stamp, age_stamp;

  int unsigned total = 0;
  int unsigned bad = 0;
  longint unsigned ncyc = 0;
  logic [31:0] mcfg = '0;   // bench copy of the live config
  logic        running = 1'b0;

  always #2 clk = ~clk;     // 250 MHz

  coarse_stamp_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .base_stamp(base_stamp), .log_stamp(log_stamp),
    .tag_stamp(tag_stamp), .age_stamp(age_stamp)
  );

  always @(posedge clk) if (rst_n) ncyc++;

  // Bit-by-bit model of a truncated right shift.
  function automatic logic [31:0] model_shift(input logic [55:0] b, input int sh);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = (i + sh < 56) ? b[i + sh] : 1'b0;
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, ncyc);
    end
  endtask

  // Full comparison at the current negedge.
  task automatic check_all(input string tag);
    logic [55:0] eb;
    eb = 56'(ncyc);
    chk({"R1 base ", tag}, 64'(base_stamp), 64'(eb));
    chk({"R2 tag ", tag}, 64'(tag_stamp), 64'(model_shift(eb, int'(mcfg[12:8]))));
    chk({"R3 age ", tag}, 64'(age_stamp), 64'(model_shift(eb, int'(mcfg[20:16]))));
    if (mcfg[7])
      chk({"R4 log ", tag}, 64'(log_stamp), 64'(model_shift(eb, int'(mcfg[4:0]))));
    else
      chk({"R5 legacy ", tag}, 64'(log_stamp), 64'(ncyc / 19200));
  endtask

  // Drive at negedge, captured on the next posedge, live afterwards (R7).
  task automatic write_cfg(input logic [31:0] w);
    cfg_we = 1'b1;
    cfg_wdata = w;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    cfg_wdata = $urandom;
    mcfg = w & 32'h001F_1F9F;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    running = 1'b1;
    @(negedge clk);
    // R6: reset state; zero shifts, legacy select
    chk("R6 cfg zero tag", 64'(tag_stamp), 64'(56'(ncyc)));
    chk("R6 legacy log", 64'(log_stamp), 64'd0);
    check_all("reset");
    idle(5);
    check_all("R6 idle");

    // R7: shift takes effect right after the write, base untouched
    write_cfg(32'h0001_0381);  // log shift 1 sel, tag 3, age 1
    check_all("R7 after write");
    chk("R7 base continuity", 64'(base_stamp), 64'(ncyc));

    // Directed shifts 14 and 24, and extremes 0 and 31
    write_cfg(32'h0018_0E8E);
    idle(7);
    check_all("shift14/24");
    write_cfg(32'h001F_009F);
    idle(3);
    check_all("shift31/0");
    chk("R4 shift 31 zero", 64'(log_stamp), 64'd0);
    chk("R3 shift 31 zero", 64'(age_stamp), 64'd0);

    // R8: garbage in reserved bits has no effect
    write_cfg(32'hFFE0_E060 | 32'h0002_0481);
    check_all("R8 reserved set");
    idle(2);
    check_all("R8 reserved later");

    // Random configs with random gaps
    for (int k = 0; k < 60; k++) begin
      write_cfg($urandom);
      check_all("random first");
      idle(1 + int'($urandom % 40));
      check_all("random later");
    end

    // R5: legacy count across millisecond boundaries
    write_cfg(32'h0004_0202 & 32'hFFFF_FF7F);
    for (int m = 1; m <= 4; m++) begin
      while (ncyc < longint'(m) * 19200 - 3) @(negedge clk);
      for (int j = 0; j < 6; j++) begin
        check_all("R5 ms boundary");
        @(negedge clk);
      end
    end
    chk("R5 legacy count reached", 64'(log_stamp), 64'd4);

    // Switch to shifted logging and back; count must not be disturbed
    write_cfg(32'h0000_0080 | 32'd10);
    check_all("R4 select shifted");
    write_cfg(32'h0000_000A);
    check_all("R5 select legacy again");

    running = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (running) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule